// File: doc/BRIEF.md
# BCD Calendar Clock Counter Chain

This block is the timekeeping core of a real-time clock. A divided oscillator enable, `tick_i`, drives an internal prescaler. Every `TICK_DIV` ticks the prescaler makes one hundredth-of-a-second step. Each step ripples through a chain of packed-BCD counters. The chain holds hundredths, seconds, minutes and hours, then the day of month, the month, a weekday and a 2-bit year.

The hour register holds two flags beside its BCD value. One flag selects 12- or 24-hour counting and the other marks the afternoon. The year shares the day register and the weekday shares the month register. Day rollover follows the length of the current month, and February is one day longer when the year count is zero.

A byte-wide register port reads and writes every field. A control register at address 0 has two bits. One stops the time base. The other freezes the visible counts without losing time: steps that arrive while frozen are counted, and are applied one per clock once the freeze is released. A write to any counter register restarts the prescaler, so a newly loaded time begins a full hundredth period.

Top module: `rtc_cal_core`

## Requirements
- R1: After reset, registers 0x00 to 0x04 read 0x00, register 0x05 reads 0x01 (day 1, year 0) and register 0x06 reads 0x01 (month 1, weekday 0).
- R2: Register 0x01 counts hundredths in BCD from 0x00 to 0x99. A step at 0x99 makes it 0x00 and advances seconds.
- R3: Registers 0x02 (seconds) and 0x03 (minutes) count in BCD from 0x00 to 0x59. Wrapping to 0x00 advances the next register (minutes, then hours).
- R4: Register 0x04 has bit 7 = 12-hour mode, bit 6 = PM and bits 5:0 = BCD hour. With bit 7 clear the hour runs 0x00 to 0x23, and wrapping to 0x00 advances the day.
- R5: With bit 7 set the hour runs 12, 1, …, 11. The step from 11 to 12 inverts bit 6. The step from 11 with bit 6 set also advances the day.
- R6: Register 0x05 has bits 7:6 = year and bits 5:0 = BCD day. After the last day of the month the day returns to 0x01 and the month advances. Months 04, 06, 09 and 11 have 30 days. Month 02 has 29 days when the year is 0 and 28 days otherwise. All other months have 31 days.
- R7: Register 0x06 has bits 7:5 = weekday and bits 4:0 = BCD month. The weekday advances on every day step and wraps from 6 to 0. Month 0x12 wraps to 0x01 and increments the year, which wraps from 3 to 0.
- R8: While bit 7 (stop) of register 0x00 is set, ticks have no effect. The prescaler keeps its phase and resumes from it.
- R9: While bit 6 (hold) of register 0x00 is set, the counts stay frozen and steps are accumulated. After hold clears, the accumulated steps are applied one per clock cycle.
- R10: A write to registers 0x01 to 0x06 loads the written byte and clears the prescaler. The next step then comes after exactly `TICK_DIV` further ticks.
- R11: With stop and hold clear, the hundredths register advances once for every `TICK_DIV` clock cycles in which `tick_i` is high.
- R12: Register 0x00 reads back stop in bit 7 and hold in bit 6, with bits 5:0 zero. Address 0x07 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Divided oscillator enable, one clock wide per tick |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |

## Verification
Each rollover is reached by loading a time just before a boundary and then supplying one prescaler period of ticks. A missed carry and a carry into the wrong register give different results. Month lengths are tried with a 30-day month, a 31-day month and February in both a zero and a non-zero year. These cases separate a fixed day limit from a per-month limit and from the leap rule. Stop and a counter write both interrupt a partly filled prescaler period, which distinguishes a frozen prescaler phase from a cleared one. Hold is released after several accumulated steps, and the hundredths are sampled on consecutive cycles to confirm a drain of one step per cycle with nothing lost and nothing added.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int BYTE_W    = 8;
  localparam int NUM_REGS  = 7;
  localparam int A_CTRL    = 0;
  localparam int A_HSEC    = 1;
  localparam int A_SEC     = 2;
  localparam int A_MIN     = 3;
  localparam int A_HOUR    = 4;
  localparam int A_DAY     = 5;
  localparam int A_MON     = 6;
  localparam int STOP_BIT  = 7;
  localparam int HOLD_BIT  = 6;

  typedef struct packed {
    logic       mode12;
    logic       pm;
    logic [5:0] hr;
  } hour_reg_t;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) bcd_inc = {v[7:4] + 4'd1, 4'd0};
    else                bcd_inc = {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [5:0] month_len(input logic [4:0] mon, input logic [1:0] yr);
    case (mon)
      5'h02:                      month_len = (yr == 2'd0) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: month_len = 6'h30;
      default:                    month_len = 6'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_tick_gate.sv
module rtc_tick_gate #(
  parameter int DIV    = 4,
  parameter int PEND_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic stop_i,
  input  logic hold_i,
  input  logic clr_i,
  output logic adv_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0]     PRESC_LAST = CW'(DIV - 1);
  localparam logic [PEND_W-1:0] PEND_MAX   = '1;

  logic [CW-1:0]     presc_q;
  logic [PEND_W-1:0] pend_q;
  logic              step, busy;

  assign busy  = (pend_q != '0);
  assign step  = tick_i && !stop_i && !clr_i && (presc_q == PRESC_LAST);
  assign adv_o = !hold_i && !clr_i && (step || busy);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                presc_q <= '0;
    else if (clr_i)             presc_q <= '0;
    else if (tick_i && !stop_i) presc_q <= (presc_q == PRESC_LAST) ? '0 : presc_q + CW'(1);
  end

  // pending steps: grow while frozen, drain one per cycle afterwards
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else if (step && !adv_o && (pend_q != PEND_MAX)) pend_q <= pend_q + PEND_W'(1);
    else if (!step && adv_o)                          pend_q <= pend_q - PEND_W'(1);
  end

  p_stop_phase_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !clr_i) |=> $stable(presc_q));
  p_clr_restart_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (presc_q == '0));
  p_drain_one_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && !clr_i && busy && !step) |=> (pend_q == $past(pend_q) - PEND_W'(1)));
endmodule

// File: rtl/rtc_bcd_ctr.sv
module rtc_bcd_ctr #(
  parameter logic [7:0] LAST = 8'h59
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       inc_i,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] val_o,
  output logic       carry_o
);
  import rtc_cal_pkg::*;

  logic [7:0] val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    val_q <= '0;
    else if (wr_i)  val_q <= wdata_i;
    else if (inc_i) val_q <= (val_q == LAST) ? 8'h00 : bcd_inc(val_q);
  end

  assign val_o   = val_q;
  assign carry_o = inc_i && !wr_i && (val_q == LAST);

  // R2 for hundredths instance, R3 for seconds/minutes instances
  p_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && val_q <= LAST) |=> (val_q <= LAST));
  p_wrap_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o |=> (val_q == 8'h00));
endmodule

// File: rtl/rtc_hour_ctr.sv
module rtc_hour_ctr (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       inc_i,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] val_o,
  output logic       carry_o
);
  import rtc_cal_pkg::*;

  hour_reg_t  q, n;
  logic       wrap;
  logic [5:0] hr_inc;

  assign hr_inc = 6'(bcd_inc({2'b00, q.hr}));

  always_comb begin
    n    = q;
    wrap = 1'b0;
    if (!q.mode12) begin
      if (q.hr == 6'h23) begin
        n.hr = 6'h00;
        wrap = 1'b1;
      end else n.hr = hr_inc;
    end else if (q.hr == 6'h12) begin
      n.hr = 6'h01;
    end else if (q.hr == 6'h11) begin
      n.hr = 6'h12;
      n.pm = !q.pm;
      wrap = q.pm;
    end else n.hr = hr_inc;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q <= '0;
    else if (wr_i)  q <= hour_reg_t'(wdata_i);
    else if (inc_i) q <= n;
  end

  assign val_o   = q;
  assign carry_o = inc_i && !wr_i && wrap;

  p_hour24_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !q.mode12 && q.hr <= 6'h23) |=> (q.hr <= 6'h23));
  p_noon_flip_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !wr_i && q.mode12 && q.hr == 6'h11) |=> (q.hr == 6'h12 && q.pm != $past(q.pm)));
endmodule

// File: rtl/rtc_date_ctr.sv
module rtc_date_ctr (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       inc_i,
  input  logic       wr_day_i,
  input  logic       wr_mon_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] day_o,
  output logic [7:0] mon_o
);
  import rtc_cal_pkg::*;

  logic [1:0] yr_q;
  logic [5:0] day_q;
  logic [2:0] wd_q;
  logic [4:0] mon_q;
  logic       step, month_end, year_end;

  assign step      = inc_i && !wr_day_i && !wr_mon_i;
  assign month_end = (day_q == month_len(mon_q, yr_q));
  assign year_end  = month_end && (mon_q == 5'h12);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      yr_q  <= 2'd0;
      day_q <= 6'h01;
    end else if (wr_day_i) begin
      yr_q  <= wdata_i[7:6];
      day_q <= wdata_i[5:0];
    end else if (step) begin
      day_q <= month_end ? 6'h01 : 6'(bcd_inc({2'b00, day_q}));
      if (year_end) yr_q <= yr_q + 2'd1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wd_q  <= 3'd0;
      mon_q <= 5'h01;
    end else if (wr_mon_i) begin
      wd_q  <= wdata_i[7:5];
      mon_q <= wdata_i[4:0];
    end else if (step) begin
      wd_q <= (wd_q == 3'd6) ? 3'd0 : wd_q + 3'd1;
      if (year_end)       mon_q <= 5'h01;
      else if (month_end) mon_q <= 5'(bcd_inc({3'b000, mon_q}));
    end
  end

  assign day_o = {yr_q, day_q};
  assign mon_o = {wd_q, mon_q};

  p_wd_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && wd_q == 3'd6) |=> (wd_q == 3'd0));
  p_day_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && month_end) |=> (day_q == 6'h01));
  p_year_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && year_end) |=> (yr_q == $past(yr_q) + 2'd1 && mon_q == 5'h01));
endmodule

// File: rtl/rtc_cal_core.sv
module rtc_cal_core
  import rtc_cal_pkg::*;
#(
  parameter int TICK_DIV = 4,
  parameter int PEND_W   = 8,
  parameter int ADDR_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o
);
  localparam int NCHAIN = 3;  // hundredths, seconds, minutes

  logic                stop_q, hold_q, cnt_wr, adv, hour_carry;
  logic [NUM_REGS-1:0] wsel;
  logic [NCHAIN-1:0]   ch_inc, ch_carry;
  logic [7:0]          ch_val [NCHAIN];
  logic [7:0]          hour_val, day_val, mon_val;

  always_comb begin
    for (int i = 0; i < NUM_REGS; i++) wsel[i] = wr_i && (addr_i == ADDR_W'(i));
  end
  assign cnt_wr = |wsel[NUM_REGS-1:1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stop_q <= 1'b0;
      hold_q <= 1'b0;
    end else if (wsel[A_CTRL]) begin
      stop_q <= wdata_i[STOP_BIT];
      hold_q <= wdata_i[HOLD_BIT];
    end
  end

  rtc_tick_gate #(.DIV(TICK_DIV), .PEND_W(PEND_W)) u_gate (
    .clk_i, .rst_ni, .tick_i,
    .stop_i(stop_q), .hold_i(hold_q), .clr_i(cnt_wr), .adv_o(adv)
  );

  for (genvar g = 0; g < NCHAIN; g++) begin : g_chain
    if (g == 0) begin : g_first
      assign ch_inc[g] = adv;
    end else begin : g_next
      assign ch_inc[g] = ch_carry[g-1];
    end
    rtc_bcd_ctr #(.LAST((g == 0) ? 8'h99 : 8'h59)) u_ctr (
      .clk_i, .rst_ni,
      .inc_i(ch_inc[g]), .wr_i(wsel[A_HSEC+g]), .wdata_i,
      .val_o(ch_val[g]), .carry_o(ch_carry[g])
    );
  end

  rtc_hour_ctr u_hour (
    .clk_i, .rst_ni,
    .inc_i(ch_carry[NCHAIN-1]), .wr_i(wsel[A_HOUR]), .wdata_i,
    .val_o(hour_val), .carry_o(hour_carry)
  );

  rtc_date_ctr u_date (
    .clk_i, .rst_ni,
    .inc_i(hour_carry), .wr_day_i(wsel[A_DAY]), .wr_mon_i(wsel[A_MON]), .wdata_i,
    .day_o(day_val), .mon_o(mon_val)
  );

  always_comb begin
    rdata_o = 8'h00;
    case (addr_i)
      ADDR_W'(A_CTRL): rdata_o = {stop_q, hold_q, 6'b0};
      ADDR_W'(A_HSEC): rdata_o = ch_val[0];
      ADDR_W'(A_SEC):  rdata_o = ch_val[1];
      ADDR_W'(A_MIN):  rdata_o = ch_val[2];
      ADDR_W'(A_HOUR): rdata_o = hour_val;
      ADDR_W'(A_DAY):  rdata_o = day_val;
      ADDR_W'(A_MON):  rdata_o = mon_val;
      default:         rdata_o = 8'h00;
    endcase
  end

  p_hold_frozen_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_q && !cnt_wr) |=> ($stable(ch_val[0]) && $stable(hour_val) && $stable(day_val)));
  p_ctrl_low_zero_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(A_CTRL)) |-> (rdata_o[5:0] == 6'b0));
  p_stop_still_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_q && !cnt_wr && !adv) |=> $stable(ch_val[0]));
endmodule

// File: tb/rtc_cal_core_bench.sv
module rtc_cal_core_bench;
  localparam int DIV = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       wr_i = 1'b0;
  logic [2:0] addr_i = 3'd0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;

  int checks = 0;
  int errors = 0;

  rtc_cal_core #(.TICK_DIV(DIV), .PEND_W(8), .ADDR_W(3)) u_rtc_cal_core (
    .clk_i, .rst_ni, .tick_i, .wr_i, .addr_i, .wdata_i, .rdata_o
  );

  always #2 clk_i = ~clk_i;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // wait_edge=1 lets one clock pass before sampling
  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string req, input bit wait_edge = 1'b1);
    if (wait_edge) @(negedge clk_i);
    addr_i = a;
    #1;
    chk(req, rdata_o, exp);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk_i);
    tick_i = 1'b1;
    repeat (n) @(negedge clk_i);
    tick_i = 1'b0;
  endtask

  // load hour/day/month with min:sec.hund at 59:59.99, then one step
  task automatic roll(input logic [7:0] hr, input logic [7:0] dy, input logic [7:0] mo);
    wr(3'd4, hr); wr(3'd5, dy); wr(3'd6, mo);
    wr(3'd3, 8'h59); wr(3'd2, 8'h59); wr(3'd1, 8'h99);
    ticks(DIV);
  endtask

  task automatic t_reset();
    rd(3'd0, 8'h00, "R1 ctrl");
    rd(3'd1, 8'h00, "R1 hund");
    rd(3'd2, 8'h00, "R1 sec");
    rd(3'd3, 8'h00, "R1 min");
    rd(3'd4, 8'h00, "R1 hour");
    rd(3'd5, 8'h01, "R1 day");
    rd(3'd6, 8'h01, "R1 month");
  endtask

  task automatic t_prescale();
    wr(3'd1, 8'h00);
    ticks(7 * DIV);
    rd(3'd1, 8'h07, "R11 seven periods");
    ticks(DIV - 1);
    rd(3'd1, 8'h07, "R11 partial period");
    ticks(1);
    rd(3'd1, 8'h08, "R11 period completes");
  endtask

  task automatic t_low_wrap();
    wr(3'd2, 8'h00); wr(3'd1, 8'h99);
    ticks(DIV);
    rd(3'd1, 8'h00, "R2 hund wraps");
    rd(3'd2, 8'h01, "R2 carry to sec");
    roll(8'h00, 8'h01, 8'h01);
    rd(3'd2, 8'h00, "R3 sec wraps");
    rd(3'd3, 8'h00, "R3 min wraps");
    rd(3'd4, 8'h01, "R3 carry to hour");
    rd(3'd5, 8'h01, "R3 day untouched");
  endtask

  task automatic t_hour24();
    roll(8'h23, 8'h05, 8'h64);
    rd(3'd4, 8'h00, "R4 23 wraps to 00");
    rd(3'd5, 8'h06, "R4 day carry");
    rd(3'd6, 8'h84, "R7 weekday step");
  endtask

  task automatic t_hour12();
    roll(8'h91, 8'h05, 8'h04);
    rd(3'd4, 8'hD2, "R5 11AM to 12PM");
    rd(3'd5, 8'h05, "R5 no day carry at noon");
    roll(8'hD2, 8'h05, 8'h04);
    rd(3'd4, 8'hC1, "R5 12PM to 1PM");
    roll(8'hD1, 8'h05, 8'h04);
    rd(3'd4, 8'h92, "R5 11PM to 12AM");
    rd(3'd5, 8'h06, "R5 midnight day carry");
    rd(3'd6, 8'h24, "R5 weekday at midnight");
  endtask

  task automatic t_month_len();
    roll(8'h23, 8'h30, 8'h04);
    rd(3'd5, 8'h01, "R6 april 30 day");
    rd(3'd6, 8'h25, "R6 april 30 month");
    roll(8'h23, 8'h31, 8'h01);
    rd(3'd5, 8'h01, "R6 jan 31 day");
    rd(3'd6, 8'h22, "R6 jan 31 month");
    roll(8'h23, 8'h28, 8'h02);
    rd(3'd5, 8'h29, "R6 feb 28 year0");
    rd(3'd6, 8'h22, "R6 feb 28 year0 month");
    roll(8'h23, 8'h29, 8'h02);
    rd(3'd5, 8'h01, "R6 feb 29 year0");
    rd(3'd6, 8'h23, "R6 feb 29 year0 month");
    roll(8'h23, 8'h68, 8'h02);
    rd(3'd5, 8'h41, "R6 feb 28 year1");
    rd(3'd6, 8'h23, "R6 feb 28 year1 month");
  endtask

  task automatic t_year();
    roll(8'h23, 8'hF1, 8'hD2);
    rd(3'd5, 8'h01, "R7 year 3 wraps, day 1");
    rd(3'd6, 8'h01, "R7 month and weekday wrap");
  endtask

  task automatic t_stop();
    wr(3'd1, 8'h00);
    ticks(2);
    wr(3'd0, 8'h80);
    ticks(10);
    rd(3'd1, 8'h00, "R8 no count while stopped");
    rd(3'd0, 8'h80, "R12 stop readback");
    wr(3'd0, 8'h00);
    ticks(1);
    rd(3'd1, 8'h00, "R8 phase kept, not yet");
    ticks(1);
    rd(3'd1, 8'h01, "R8 phase kept, step");
  endtask

  task automatic t_hold();
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h40);
    ticks(5 * DIV);
    rd(3'd1, 8'h00, "R9 frozen under hold");
    rd(3'd0, 8'h40, "R12 hold readback");
    wr(3'd0, 8'h00);
    rd(3'd1, 8'h00, "R9 release edge", 1'b0);
    rd(3'd1, 8'h01, "R9 first drain");
    rd(3'd1, 8'h02, "R9 second drain");
    repeat (3) @(negedge clk_i);
    rd(3'd1, 8'h05, "R9 all applied", 1'b0);
    repeat (4) @(negedge clk_i);
    rd(3'd1, 8'h05, "R9 nothing extra", 1'b0);
  endtask

  task automatic t_write_restart();
    wr(3'd1, 8'h10);
    rd(3'd1, 8'h10, "R10 load");
    ticks(DIV - 1);
    wr(3'd1, 8'h20);
    ticks(DIV - 1);
    rd(3'd1, 8'h20, "R10 full period after write");
    ticks(1);
    rd(3'd1, 8'h21, "R10 step after period");
  endtask

  task automatic t_ctrl();
    wr(3'd0, 8'hFF);
    rd(3'd0, 8'hC0, "R12 low bits zero");
    rd(3'd7, 8'h00, "R12 unused address");
    wr(3'd0, 8'h00);
    rd(3'd0, 8'h00, "R12 cleared");
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_prescale();
    t_low_wrap();
    t_hour24();
    t_hour12();
    t_month_len();
    t_year();
    t_stop();
    t_hold();
    t_write_restart();
    t_ctrl();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule